// File: doc/BRIEF.md
# Parallel-Bus Converter Read Sequencer

This block sits on the host side of an eight-channel, 12-bit analog-to-digital converter that uses a parallel bus. A single request carrying a channel number starts a complete sample cycle. The block writes the channel address with a write strobe and waits an acquisition interval. It then drives a convert-start pulse and watches the converter's active-low end-of-conversion line for a falling edge. On that edge it runs a combined chip-select/read cycle that captures the 12-bit result. The result goes to the requester on a one-cycle valid strobe, together with the channel it belongs to.

Readings on the converter bus are kept away from sensitive moments. A read never overlaps a conversion. A guard interval must also pass between the end of one read and the next convert start. This guard puts a floor on the spacing of back-to-back samples. If the end-of-conversion edge does not arrive in time, the block gives up, returns to idle and raises a one-cycle error flag.

Every strobe width, the acquisition wait, the guard interval and the timeout are parameters counted in system-clock cycles.

Top module: `adc_par_host`

## Requirements
- R1: After reset, `adc_wr_n`, `adc_convst_n`, `adc_cs_n` and `adc_rd_n` are high, `req_ready` is high, and `res_valid` and `err_timeout` are low.
- R2: A request (`req_valid` high) is taken only while `req_ready` is high. Requests presented while busy have no effect: the channel written and the result returned belong to the accepted request.
- R3: After acceptance, `adc_wr_n` goes low for exactly WR_CYC cycles while `adc_addr` carries the requested channel. The converter takes the channel on the rising edge of `adc_wr_n`.
- R4: `adc_convst_n` goes low for exactly CONVST_CYC cycles, and its rising edge starts the conversion. Its falling edge comes no sooner than ACQ_CYC cycles after `adc_wr_n` rose. The two strobes never overlap.
- R5: A falling edge on `adc_eoc_n` starts the read cycle only while the block is waiting for a conversion. An edge at any other time is ignored, and no read follows it.
- R6: `adc_cs_n` and `adc_rd_n` go low together for exactly RD_CYC cycles. `adc_data` is captured in the last cycle of that window.
- R7: `res_valid` is high for exactly one cycle per completed sample. `res_data` carries the captured word and `res_chan` the channel.
- R8: No read strobe is driven between the rising edge of `adc_convst_n` and the end-of-conversion edge. No read strobe is driven while either the write strobe or the convert strobe is low.
- R9: At least GUARD_CYC cycles pass between the rising edge of `adc_rd_n` and the next falling edge of `adc_convst_n`.
- R10: If no end-of-conversion edge is seen within TIMEOUT_CYC cycles after the convert-start pulse, `err_timeout` pulses high for one cycle and the block returns to idle. No `res_valid` is produced for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Sample request |
| req_chan | input | CHAN_W | Channel to sample |
| req_ready | output | 1 | High when idle and able to take a request |
| adc_addr | output | CHAN_W | Channel address toward the converter |
| adc_wr_n | output | 1 | Active-low address write strobe |
| adc_convst_n | output | 1 | Active-low convert-start pulse |
| adc_eoc_n | input | 1 | Active-low end-of-conversion pulse from the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_rd_n | output | 1 | Active-low read strobe |
| adc_data | input | DATA_W | Conversion result bus |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Captured conversion result |
| res_chan | output | CHAN_W | Channel of the result |
| err_timeout | output | 1 | One-cycle end-of-conversion timeout flag |

## Verification
The assertions assume two things about the converter side. First, `adc_eoc_n` is an asynchronous, active-low pulse that lasts at least two system-clock cycles, so the synchronizer catches every edge. Second, `adc_data` is stable for the whole read window. The bench's converter model meets both: it holds the end-of-conversion line low for two cycles and drives the data bus from a register that only changes at a convert start. Requests are driven only at falling clock edges. A spurious end-of-conversion pulse is placed in the acquisition phase to test R5. Requests that arrive while busy are held for several cycles and carry a different channel.

// File: rtl/adc_par_pkg.sv
package adc_par_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_ACQ   = 3'd2,
      ST_START = 3'd3,
      ST_CONV  = 3'd4,
      ST_READ  = 3'd5
   } host_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_par_phase_timer.sv
module adc_par_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("phase timer width must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_par_eoc_detect.sv
module adc_par_eoc_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eoc_n_in,
   output logic eoc_fall
);

   logic last_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("end-of-conversion synchronizer needs at least two stages");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         logic stage_q;
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q <= 1'b1;
               else        stage_q <= eoc_n_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q <= 1'b1;
               else        stage_q <= g_sync[i-1].stage_q;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= g_sync[SYNC_STAGES-1].stage_q;
   end

   assign eoc_fall = last_q & ~g_sync[SYNC_STAGES-1].stage_q;

   // R5
   eoc_fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_fall |=> !eoc_fall);

endmodule

// File: rtl/adc_par_guard.sv
module adc_par_guard #(
   parameter int GUARD_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_active,
   output logic guard_clear
);

   localparam int GW = $clog2(GUARD_CYC + 1);

   logic [GW-1:0] left_q;

   generate
      if (GUARD_CYC < 1) begin : g_bad_guard
         $error("guard interval must be at least one cycle");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (rd_active) begin
         left_q <= GW'(GUARD_CYC);
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign guard_clear = (left_q == '0);

   // R9
   guard_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_active |=> !guard_clear);

endmodule

// File: rtl/adc_par_host.sv
module adc_par_host
   import adc_par_pkg::*;
#(
   parameter int CHAN_W      = 3,
   parameter int DATA_W      = 12,
   parameter int WR_CYC      = 2,
   parameter int ACQ_CYC     = 30,
   parameter int CONVST_CYC  = 2,
   parameter int RD_CYC      = 3,
   parameter int GUARD_CYC   = 5,
   parameter int TIMEOUT_CYC = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CHAN_W-1:0] req_chan,
   output logic              req_ready,
   output logic [CHAN_W-1:0] adc_addr,
   output logic              adc_wr_n,
   output logic              adc_convst_n,
   input  logic              adc_eoc_n,
   output logic              adc_cs_n,
   output logic              adc_rd_n,
   input  logic [DATA_W-1:0] adc_data,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [CHAN_W-1:0] res_chan,
   output logic              err_timeout
);

   localparam int MAX_A = max_of(WR_CYC, ACQ_CYC);
   localparam int MAX_B = max_of(CONVST_CYC, RD_CYC);
   localparam int MAX_C = max_of(max_of(MAX_A, MAX_B), TIMEOUT_CYC);
   localparam int CW    = $clog2(MAX_C + 1);

   generate
      if (WR_CYC < 1 || ACQ_CYC < 1 || CONVST_CYC < 1 || RD_CYC < 1) begin : g_bad_phase
         $error("every phase length must be at least one cycle");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_tmo
         $error("timeout must be at least two cycles");
      end
      if (CHAN_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("channel and data widths must be positive");
      end
   endgenerate

   host_state_t       state_q, state_d;
   logic [CHAN_W-1:0] chan_q;
   logic              tmr_load;
   logic [CW-1:0]     tmr_val;
   logic              tmr_done;
   logic              eoc_fall;
   logic              guard_clear;
   logic              rd_active;
   logic              done_set;
   logic              tmo_set;

   adc_par_phase_timer #(.CNT_W(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   adc_par_eoc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_eoc (
      .clk      (clk),
      .rst_n    (rst_n),
      .eoc_n_in (adc_eoc_n),
      .eoc_fall (eoc_fall)
   );

   adc_par_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_active   (rd_active),
      .guard_clear (guard_clear)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      done_set = 1'b0;
      tmo_set  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               state_d  = ST_ADDR;
               tmr_load = 1'b1;
               tmr_val  = CW'(WR_CYC - 1);
            end
         end
         ST_ADDR: begin
            if (tmr_done) begin
               state_d  = ST_ACQ;
               tmr_load = 1'b1;
               tmr_val  = CW'(ACQ_CYC - 1);
            end
         end
         ST_ACQ: begin
            if (tmr_done && guard_clear) begin
               state_d  = ST_START;
               tmr_load = 1'b1;
               tmr_val  = CW'(CONVST_CYC - 1);
            end
         end
         ST_START: begin
            if (tmr_done) begin
               state_d  = ST_CONV;
               tmr_load = 1'b1;
               tmr_val  = CW'(TIMEOUT_CYC - 1);
            end
         end
         ST_CONV: begin
            if (eoc_fall) begin
               state_d  = ST_READ;
               tmr_load = 1'b1;
               tmr_val  = CW'(RD_CYC - 1);
            end else if (tmr_done) begin
               state_d = ST_IDLE;
               tmo_set = 1'b1;
            end
         end
         ST_READ: begin
            if (tmr_done) begin
               state_d  = ST_IDLE;
               done_set = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         chan_q      <= '0;
         res_valid   <= 1'b0;
         res_data    <= '0;
         err_timeout <= 1'b0;
      end else begin
         state_q     <= state_d;
         res_valid   <= done_set;
         err_timeout <= tmo_set;
         if (state_q == ST_IDLE && req_valid) chan_q <= req_chan;
         if (done_set) res_data <= adc_data;
      end
   end

   assign rd_active    = (state_q == ST_READ);
   assign req_ready    = (state_q == ST_IDLE);
   assign adc_addr     = chan_q;
   assign res_chan     = chan_q;
   assign adc_wr_n     = (state_q != ST_ADDR);
   assign adc_convst_n = (state_q != ST_START);
   assign adc_cs_n     = !rd_active;
   assign adc_rd_n     = !rd_active;

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |-> adc_wr_n && adc_convst_n && adc_rd_n && !res_valid);

   // R2
   accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_wr_n) |-> $past(req_valid) && $past(req_ready));

   // R6
   cs_rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n == adc_rd_n);

   // R8
   no_read_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rd_n |-> adc_convst_n && adc_wr_n);

   // R4
   strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!adc_wr_n && !adc_convst_n));

   // R9
   guard_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_convst_n) |-> $past(guard_clear));

   // R7
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R10
   timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |-> req_ready && !res_valid);

endmodule

// File: tb/adc_par_host_tb_top.sv
module adc_par_host_tb_top;

   localparam int CHAN_W      = 3;
   localparam int DATA_W      = 12;
   localparam int WR_CYC      = 2;
   localparam int ACQ_CYC     = 4;
   localparam int CONVST_CYC  = 2;
   localparam int RD_CYC      = 3;
   localparam int GUARD_CYC   = 12;
   localparam int TIMEOUT_CYC = 40;
   localparam int CONV_LAT    = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [CHAN_W-1:0] req_chan = '0;
   logic              req_ready;
   logic [CHAN_W-1:0] adc_addr;
   logic              adc_wr_n, adc_convst_n, adc_cs_n, adc_rd_n;
   logic              adc_eoc_n = 1'b1;
   logic [DATA_W-1:0] adc_data;
   logic              res_valid;
   logic [DATA_W-1:0] res_data;
   logic [CHAN_W-1:0] res_chan;
   logic              err_timeout;

   always #10 clk = ~clk;

   adc_par_host #(
      .CHAN_W(CHAN_W), .DATA_W(DATA_W), .WR_CYC(WR_CYC), .ACQ_CYC(ACQ_CYC),
      .CONVST_CYC(CONVST_CYC), .RD_CYC(RD_CYC), .GUARD_CYC(GUARD_CYC),
      .TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_ready(req_ready), .adc_addr(adc_addr), .adc_wr_n(adc_wr_n),
      .adc_convst_n(adc_convst_n), .adc_eoc_n(adc_eoc_n), .adc_cs_n(adc_cs_n),
      .adc_rd_n(adc_rd_n), .adc_data(adc_data), .res_valid(res_valid),
      .res_data(res_data), .res_chan(res_chan), .err_timeout(err_timeout)
   );

   function automatic logic [DATA_W-1:0] sample_of(input logic [CHAN_W-1:0] ch, input int n);
      return (DATA_W'(ch) * 12'd291 + DATA_W'(n) * 12'd7) ^ 12'hA5C;
   endfunction

   // converter model
   logic              mute = 1'b0;
   logic              spur_arm = 1'b0;
   logic              m_wr_q = 1'b1, m_cv_q = 1'b1, m_busy = 1'b0;
   logic [CHAN_W-1:0] m_addr = '0;
   logic [DATA_W-1:0] m_res = '0;
   int                m_lat = 0, m_nconv = 0, m_eoc_lo = 0;

   always @(posedge clk) begin
      m_wr_q <= adc_wr_n;
      m_cv_q <= adc_convst_n;
      if (m_eoc_lo > 0) begin
         m_eoc_lo <= m_eoc_lo - 1;
         if (m_eoc_lo == 1) adc_eoc_n <= 1'b1;
      end
      if (!m_wr_q && adc_wr_n) begin
         m_addr <= adc_addr;
         if (spur_arm) begin
            adc_eoc_n <= 1'b0;
            m_eoc_lo  <= 2;
         end
      end
      if (!m_cv_q && adc_convst_n) begin
         m_busy  <= 1'b1;
         m_lat   <= CONV_LAT;
         m_res   <= sample_of(m_addr, m_nconv);
         m_nconv <= m_nconv + 1;
      end else if (m_busy) begin
         m_lat <= m_lat - 1;
         if (m_lat == 1) begin
            m_busy <= 1'b0;
            if (!mute) begin
               adc_eoc_n <= 1'b0;
               m_eoc_lo  <= 2;
            end
         end
      end
   end

   assign adc_data = (!adc_cs_n && !adc_rd_n) ? m_res : '0;

   // scoreboard
   typedef struct {
      bit                is_err;
      logic [CHAN_W-1:0] ch;
      logic [DATA_W-1:0] d;
   } exp_t;

   exp_t q[$];
   int   total = 0, bad = 0;
   int   drv_n = 0;
   logic [CHAN_W-1:0] cur_ch = '0;
   bit   finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
      end
   endtask

   // monitor
   logic p_wr = 1'b1, p_cv = 1'b1, p_rd = 1'b1, p_val = 1'b0, p_err = 1'b0;
   int   wr_run = 0, cv_run = 0, rd_run = 0, acq_gap = 0, since_rd = 0;
   int   rd_in_window = 0;
   bit   had_read = 0, cs_mismatch = 0, rd_in_conv = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!adc_wr_n) begin
            wr_run++;
            if (adc_addr != cur_ch) cs_mismatch = 1;
         end else if (!p_wr) begin
            check(wr_run == WR_CYC, "R3", "write strobe width", wr_run, WR_CYC);
            check(!cs_mismatch, "R3", "address during write", adc_addr, cur_ch);
            cs_mismatch = 0;
            wr_run = 0;
            acq_gap = 0;
            rd_in_window = 0;
         end
         if (adc_wr_n && adc_convst_n && p_cv) acq_gap++;
         if (!adc_rd_n) rd_in_window++;
         if (!adc_convst_n && p_cv) begin
            check(acq_gap >= ACQ_CYC, "R4", "acquisition gap", acq_gap, ACQ_CYC);
            check(rd_in_window == 0, "R5", "reads before start", rd_in_window, 0);
            if (had_read)
               check(since_rd >= GUARD_CYC, "R9", "read-to-start guard", since_rd, GUARD_CYC);
         end
         if (!adc_convst_n) cv_run++;
         else if (!p_cv) begin
            check(cv_run == CONVST_CYC, "R4", "convert strobe width", cv_run, CONVST_CYC);
            cv_run = 0;
         end
         if (!adc_rd_n) begin
            rd_run++;
            since_rd = 0;
            if (adc_cs_n) cs_mismatch = 1;
            if (m_busy) rd_in_conv = 1;
         end else begin
            since_rd++;
            if (!p_rd) begin
               had_read = 1;
               check(rd_run == RD_CYC, "R6", "read strobe width", rd_run, RD_CYC);
               check(!cs_mismatch, "R6", "chip select paired with read", 0, 0);
               check(!rd_in_conv, "R8", "read during conversion", 1, 0);
               rd_run = 0;
               cs_mismatch = 0;
               rd_in_conv = 0;
            end
         end
         if (p_val) check(!res_valid, "R7", "valid width", res_valid, 0);
         if (p_err) check(!err_timeout, "R10", "error width", err_timeout, 0);
         if (res_valid || err_timeout) begin
            if (q.size() == 0) begin
               check(0, res_valid ? "R7" : "R10", "unexpected output", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (e.is_err) begin
                  check(err_timeout && !res_valid, "R10", "timeout flag", err_timeout, 1);
               end else begin
                  check(res_valid && !err_timeout, "R7", "result strobe", res_valid, 1);
                  check(res_data == e.d, "R6", "captured data", res_data, e.d);
                  check(res_chan == e.ch, "R2", "result channel", res_chan, e.ch);
               end
            end
         end
         p_wr  = adc_wr_n;
         p_cv  = adc_convst_n;
         p_rd  = adc_rd_n;
         p_val = res_valid;
         p_err = err_timeout;
      end
   end

   // driver
   task automatic do_req(input logic [CHAN_W-1:0] ch, input bit mute_it,
                         input bit spur, input bit poke);
      exp_t e;
      while (!req_ready) @(negedge clk);
      mute     = mute_it;
      spur_arm = spur;
      cur_ch   = ch;
      e.is_err = mute_it;
      e.ch     = ch;
      e.d      = mute_it ? '0 : sample_of(ch, drv_n);
      q.push_back(e);
      drv_n++;
      req_chan  = ch;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         // R2: requests while busy must have no effect
         req_chan  = ~ch;
         req_valid = 1'b1;
         repeat (3) @(negedge clk);
         req_valid = 1'b0;
      end
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      spur_arm = 1'b0;
      mute     = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(adc_wr_n && adc_convst_n && adc_cs_n && adc_rd_n, "R1", "strobes idle", 0, 1);
      check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      check(!res_valid && !err_timeout, "R1", "flags low after reset", res_valid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      do_req(3'd3, 0, 0, 0);
      do_req(3'd5, 0, 0, 1);
      do_req(3'd0, 0, 0, 0);
      do_req(3'd7, 0, 0, 0);
      do_req(3'd2, 0, 1, 0);
      do_req(3'd6, 1, 0, 0);
      do_req(3'd1, 0, 0, 0);
      do_req(3'd4, 0, 0, 1);
      repeat (50) @(negedge clk);
      check(q.size() == 0, "R7", "all results returned", q.size(), 0);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(negedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R7 act=%0d exp=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule